// File: doc/BRIEF.md
# Variable-Latency Execute Stage Stall Controller

This block stands in for the single execute stage of an in-order pipeline. Every instruction that enters carries a 3-bit class code. The class fixes how many whole clock cycles the instruction keeps the stage, which is its execution time rounded up to a whole number of cycles. The stage holds only one instruction at a time. While an instruction still has cycles left after the current one, the block raises a stall towards the upstream stages so that the next instruction waits.

The previous stage presents `in_valid` and `in_class`. It holds both steady while `stall_up` is high. An instruction is taken on a rising edge where `in_valid` is high and `stall_up` is low. The downstream stage sees a one-cycle `out_valid` pulse, together with the class, in the last cycle the instruction spends in the stage. A 16-bit counter totals every cycle in which the stall was raised, which gives the number of structural-hazard stall cycles a program suffers.

Top module: `ex_hold_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `stall_up` = 0, `out_valid` = 0 and `stall_count` = 0.
- R2: Class code 0 (all other instructions) holds the stage for 1 cycle. `out_valid` is high in the cycle after acceptance, `stall_up` stays low, and no stall cycles are added.
- R3: Class codes 1 (load), 2 (integer multiply), 4 (float add) and 5 (float subtract) hold the stage for 2 cycles, which adds exactly 1 stall cycle.
- R4: Class codes 3 (integer divide) and 6 (float multiply) hold the stage for 3 cycles, which adds exactly 2 stall cycles.
- R5: Class code 7 (float divide) holds the stage for 4 cycles, which adds exactly 3 stall cycles.
- R6: After acceptance of an instruction that occupies C cycles, `stall_up` is high for the first C-1 occupancy cycles and low in the last one. A waiting instruction is accepted at the edge that ends that last cycle, so back-to-back issue leaves no idle cycle.
- R7: `out_valid` is high for exactly one cycle per instruction, in its last occupancy cycle and never together with `stall_up`, and `out_class` then shows that instruction's class.
- R8: `stall_count` rises by one after each cycle in which `stall_up` is high, and holds otherwise.
- R9: `stall_count` saturates at 65535 and stays there while stalls continue.
- R10: Input with `in_valid` low has no effect. A class change on `in_class` while `stall_up` is high does not alter the class of the instruction already in the stage.
- R11: A back-to-back program of 15 loads, 10 integer multiplies, 5 integer divides, 10 float adds, 5 float subtracts, 15 float multiplies, 5 float divides and 35 other instructions, in any order, adds exactly 95 stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered by the previous stage |
| in_class | input | 3 | Class code of the offered instruction |
| stall_up | output | 1 | Hold request to the upstream stages |
| out_valid | output | 1 | One-cycle pulse in an instruction's last occupancy cycle |
| out_class | output | 3 | Class of the instruction in the stage |
| stall_count | output | 16 | Saturating total of stall cycles |

## Verification
The bound assertions check on every cycle the local rules of the block. These are the reset state, the single-step and hold behaviour of the counter, the saturation ceiling, that the valid pulse and the stall never coincide, that the class in the stage stays fixed during a stall, that a stall run never exceeds three cycles, and the immediate response to code 0 and code 7. Only the bench's scenarios can show the facts that span a whole instruction or a whole program. These are the exact stall length for each class, that the hand-off between back-to-back instructions leaves no gap, that the mixed program totals 95, and that saturation is reached after tens of thousands of stalls.

// File: rtl/ex_hold_pkg.sv
package ex_hold_pkg;

    localparam int CLS_W   = 3;
    localparam int MAX_OCC = 4;
    localparam int REM_W   = $clog2(MAX_OCC);

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_IMUL  = 3'd2,
        CLS_IDIV  = 3'd3,
        CLS_FADD  = 3'd4,
        CLS_FSUB  = 3'd5,
        CLS_FMUL  = 3'd6,
        CLS_FDIV  = 3'd7
    } ex_cls_e;

    typedef struct packed {
        logic             busy;
        logic [REM_W-1:0] rem;
        ex_cls_e          cls;
    } ex_slot_t;

    // Cycles left after the entry cycle: ceil(execution time) - 1.
    function automatic logic [REM_W-1:0] extra_cycles(ex_cls_e c);
        logic [REM_W-1:0] r;
        case (c)
            CLS_LOAD, CLS_IMUL, CLS_FADD, CLS_FSUB: r = 2'd1;
            CLS_IDIV, CLS_FMUL:                     r = 2'd2;
            CLS_FDIV:                               r = 2'd3;
            default:                                r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ex_occ_decode.sv
module ex_occ_decode
    import ex_hold_pkg::*;
(
    input  ex_cls_e          cls,
    output logic [REM_W-1:0] hold_m1
);
    always_comb hold_m1 = extra_cycles(cls);
endmodule

// File: rtl/ex_occ_timer.sv
module ex_occ_timer
    import ex_hold_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [REM_W-1:0] take_rem,
    input  ex_cls_e          take_cls,
    output logic             busy_hold,
    output logic             last_cycle,
    output ex_cls_e          cur_cls
);
    ex_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q.busy <= 1'b0;
            slot_q.rem  <= '0;
            slot_q.cls  <= CLS_OTHER;
        end else if (take) begin
            slot_q.busy <= 1'b1;
            slot_q.rem  <= take_rem;
            slot_q.cls  <= take_cls;
        end else if (slot_q.rem != '0) begin
            slot_q.rem  <= slot_q.rem - 1'b1;
        end else begin
            slot_q.busy <= 1'b0;
        end
    end

    always_comb begin
        busy_hold  = (slot_q.rem != '0);
        last_cycle = slot_q.busy && (slot_q.rem == '0);
        cur_cls    = slot_q.cls;
    end
endmodule

// File: rtl/ex_stall_tally.sv
module ex_stall_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            total <= '0;
        else if (bump && total != CNT_TOP)
            total <= total + CNT_ONE;
    end
endmodule

// File: rtl/ex_hold_ctrl.sv
module ex_hold_ctrl
    import ex_hold_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    output logic             stall_up,
    output logic             out_valid,
    output logic [2:0]       out_class,
    output logic [CNT_W-1:0] stall_count
);
    ex_cls_e          cls_in;
    ex_cls_e          cls_cur;
    logic [REM_W-1:0] rem_load;
    logic             take;

    assign cls_in = ex_cls_e'(in_class);
    assign take   = in_valid && !stall_up;

    ex_occ_decode u_dec (
        .cls     (cls_in),
        .hold_m1 (rem_load)
    );

    ex_occ_timer u_tmr (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_rem   (rem_load),
        .take_cls   (cls_in),
        .busy_hold  (stall_up),
        .last_cycle (out_valid),
        .cur_cls    (cls_cur)
    );

    assign out_class = cls_cur;

    ex_stall_tally #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .bump  (stall_up),
        .total (stall_count)
    );
endmodule

// File: rtl/ex_hold_ctrl_chk.sv
module ex_hold_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic             stall_up,
    input logic             out_valid,
    input logic [2:0]       out_class,
    input logic [CNT_W-1:0] stall_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [2:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)           run_q <= 3'd0;
        else if (stall_up) run_q <= run_q + 3'd1;
        else               run_q <= 3'd0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!stall_up && !out_valid && stall_count == '0));

    assert_other_single_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall_up && in_class == 3'd0) |=> (out_valid && !stall_up));

    assert_fdiv_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall_up && in_class == 3'd7) |=> stall_up);

    assert_stall_run_max_R6: assert property (@(posedge clk) disable iff (rst)
        stall_up |-> (run_q < 3'd3));

    assert_pulse_not_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !stall_up);

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
        (stall_up && stall_count != TOP) |=> (stall_count == $past(stall_count) + 1'b1));

    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !stall_up |=> $stable(stall_count));

    assert_cnt_ceiling_R9: assert property (@(posedge clk) disable iff (rst)
        (stall_count == TOP) |=> (stall_count == TOP));

    assert_class_held_R10: assert property (@(posedge clk) disable iff (rst)
        stall_up |=> $stable(out_class));
endmodule

bind ex_hold_ctrl ex_hold_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .stall_up    (stall_up),
    .out_valid   (out_valid),
    .out_class   (out_class),
    .stall_count (stall_count)
);

// File: tb/ex_hold_ctrl_test.sv
`timescale 1ns/1ps
module ex_hold_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_class = 3'd0;
    logic        stall_up, out_valid;
    logic [2:0]  out_class;
    logic [15:0] stall_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // reference state
    int       m_rem  = 0;
    bit       m_busy = 0;
    bit [2:0] m_cls  = 0;
    int       m_cnt  = 0;
    bit       last_acc = 0;
    int       pulses = 0;

    always #5 clk = ~clk;

    ex_hold_ctrl uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .stall_up(stall_up), .out_valid(out_valid), .out_class(out_class),
        .stall_count(stall_count)
    );

    function automatic int occ(input bit [2:0] c);
        case (c)
            3'd1, 3'd2, 3'd4, 3'd5: return 2;
            3'd3, 3'd6:             return 3;
            3'd7:                   return 4;
            default:                return 1;
        endcase
    endfunction

    function automatic string grp(input bit [2:0] c);
        case (occ(c))
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit st, acc;
        st  = (m_rem != 0);
        acc = in_valid && !st && !rst;
        @(posedge clk);
        #1;
        cycles++;
        if (rst) begin
            m_rem = 0; m_busy = 0; m_cls = 0; m_cnt = 0;
        end else begin
            if (st && m_cnt != 65535) m_cnt++;
            if (acc) begin
                m_busy = 1; m_rem = occ(in_class) - 1; m_cls = in_class;
            end else if (m_rem != 0) m_rem--;
            else m_busy = 0;
        end
        last_acc = acc;
        if (out_valid) pulses++;
        if (!rst) begin
            check(stall_up == (m_rem != 0), "R6 stall", int'(stall_up), int'(m_rem != 0));
            check(out_valid == (m_busy && m_rem == 0), "R7 out_valid",
                  int'(out_valid), int'(m_busy && m_rem == 0));
            if (m_busy && m_rem == 0)
                check(out_class == m_cls, "R7 out_class", int'(out_class), int'(m_cls));
            check(int'(stall_count) == m_cnt, "R8 stall_count", int'(stall_count), m_cnt);
        end
    endtask

    task automatic issue(input bit [2:0] c);
        in_valid = 1'b1;
        in_class = c;
        do tick(); while (!last_acc);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles >= 190000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit [2:0] prog [100];
        int base, k;
        void'($urandom(32'd4471));

        // R1: reset state
        rst = 1'b1;
        tick(); tick();
        check(!stall_up && !out_valid, "R1 outputs idle", int'(stall_up | out_valid), 0);
        check(stall_count == 16'd0, "R1 count zero", int'(stall_count), 0);
        rst = 1'b0;
        idle(2);

        // R2..R5: each class alone
        for (int c = 0; c < 8; c++) begin
            base = int'(stall_count);
            pulses = 0;
            issue(3'(c));
            idle(6);
            check(int'(stall_count) - base == occ(3'(c)) - 1, grp(3'(c)),
                  int'(stall_count) - base, occ(3'(c)) - 1);
            check(pulses == 1, "R7 single pulse", pulses, 1);
        end

        // R6: back-to-back pairs, no gap at hand-off
        for (int a = 0; a < 8; a++) begin
            issue(3'(a));
            issue(3'(7 - a));
            check(int'(stall_up) == int'(occ(3'(7 - a)) > 1), "R6 handoff",
                  int'(stall_up), int'(occ(3'(7 - a)) > 1));
        end
        idle(5);

        // R10: in_valid low has no effect
        base = int'(stall_count);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b0;
            in_class = 3'($urandom_range(0, 7));
            tick();
        end
        check(int'(stall_count) == base, "R10 idle count", int'(stall_count), base);
        check(pulses == 0, "R10 idle pulses", pulses, 0);

        // R10: class changes during a stall
        issue(3'd7);
        in_class = 3'd0;
        while (!out_valid) tick();
        check(out_class == 3'd7, "R10 held class", int'(out_class), 7);
        idle(4);

        // random traffic with gaps
        for (int i = 0; i < 300; i++) begin
            issue(3'($urandom_range(0, 7)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(5);

        // R11: mixed program of 100 instructions, shuffled
        k = 0;
        for (int i = 0; i < 15; i++) prog[k++] = 3'd1;
        for (int i = 0; i < 10; i++) prog[k++] = 3'd2;
        for (int i = 0; i < 5;  i++) prog[k++] = 3'd3;
        for (int i = 0; i < 10; i++) prog[k++] = 3'd4;
        for (int i = 0; i < 5;  i++) prog[k++] = 3'd5;
        for (int i = 0; i < 15; i++) prog[k++] = 3'd6;
        for (int i = 0; i < 5;  i++) prog[k++] = 3'd7;
        for (int i = 0; i < 35; i++) prog[k++] = 3'd0;
        for (int i = 99; i > 0; i--) begin
            int j;
            bit [2:0] t;
            j = int'($urandom_range(0, i));
            t = prog[i]; prog[i] = prog[j]; prog[j] = t;
        end
        do_reset();
        for (int i = 0; i < 100; i++) issue(prog[i]);
        idle(6);
        check(stall_count == 16'd95, "R11 program stalls", int'(stall_count), 95);

        // R9: saturation
        do_reset();
        for (int i = 0; i < 22000; i++) issue(3'd7);
        idle(6);
        check(stall_count == 16'hFFFF, "R9 saturated", int'(stall_count), 65535);
        issue(3'd6);
        idle(5);
        check(stall_count == 16'hFFFF, "R9 stays saturated", int'(stall_count), 65535);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule